// File: doc/BRIEF.md
# Stop-Mode Wake-Up Recovery Controller

This block controls a low-power stop state for a small microcontroller. A stop request accepted while the system runs turns off the CPU clock enable and the peripheral clock enable. The block then waits for a wake source. That source is an interrupt request, a break request or reset. After an interrupt or break wake it counts a recovery delay on the reference clock, and only then turns the clock enables back on. Reset skips the delay.

The recovery delay is either long or short. The choice comes from a configuration input that is captured at the moment stop is entered. The recovery counter stays at zero for the whole time the block is stopped and starts counting only when recovery begins. When the delay is over, a one-cycle `wake_done` pulse marks the final recovery cycle. In the first cycle with clocks running again, a one-cycle `stack_ok` strobe tells the interrupt logic that it may begin stacking.

A sticky flag records whether the last exit from stop was caused by a break. Software reads the flag, and clears it by writing 0 to the status port.

The state machine has three states:
- `ST_RUN`: clocks are enabled.
- `ST_STOP`: clocks are gated and the counter is held cleared.
- `ST_RECOVER`: clocks are still gated and the counter runs.

It has four transitions:
- stop accept: `ST_RUN` to `ST_STOP`, on `stop_req`.
- wake: `ST_STOP` to `ST_RECOVER`, on `irq_req` or `brk_req`.
- recovery done: `ST_RECOVER` to `ST_RUN`, at the terminal count.
- reset: any state to `ST_RUN`, asynchronously.

Top module: `stop_wake_ctrl`

## Requirements
- R1: After reset, `cpu_clk_en` and `per_clk_en` are 1, and `brk_flag`, `wake_done` and `stack_ok` are 0.
- R2: When `stop_req` is sampled high in run, both clock enables are 0 from the next cycle on, and they stay 0 through stop and recovery.
- R3: In stop, only `irq_req` or `brk_req` (or reset) ends the stop state. Without a wake source the block stays stopped indefinitely.
- R4: The clock enables return to 1 exactly LONG_CYCLES (4096) cycles after the clock edge that samples the wake when the captured `cfg_short` is 0, and exactly SHORT_CYCLES (32) cycles after it when the captured value is 1. The recovery counter is 0 whenever the block is not recovering.
- R5: `cfg_short` is captured only on the edge that accepts stop. Changing it during stop or recovery does not change the delay.
- R6: `wake_done` is high for exactly one cycle per recovery: the last recovery cycle, just before the clocks return.
- R7: `stack_ok` is high for exactly one cycle: the first cycle with clocks enabled after a recovery. It is never high during stop or recovery.
- R8: A `brk_req` that ends stop sets `brk_flag` to 1, meaning the exit was caused by a break. A wake by `irq_req` alone leaves it at 0. A `brk_req` while running does not set it.
- R9: A cycle with `reg_wr_en`=1 and `reg_wr_data`=0 clears `brk_flag`. Writing 1 has no effect. A break exit in the same cycle as a clear leaves the flag at 1.
- R10: Reset asserted during stop or recovery returns the block at once to run, with both clocks enabled and `brk_flag` cleared. The next recovery counts a full, fresh delay.
- R11: `stop_req` during stop or recovery is ignored. `irq_req` and `brk_req` during run leave the clocks enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | Request to enter stop (acted on only in run) |
| irq_req | input | 1 | Interrupt wake source |
| brk_req | input | 1 | Break wake source |
| cfg_short | input | 1 | 1 selects short recovery, 0 selects long |
| reg_wr_en | input | 1 | Status register write strobe |
| reg_wr_data | input | 1 | Write data for the break-exit flag (0 clears) |
| brk_flag | output | 1 | Sticky break-exit status |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| wake_done | output | 1 | One-cycle pulse in the last recovery cycle |
| stack_ok | output | 1 | One-cycle strobe: interrupt stacking may begin |

## Verification
The assertions check these behaviours on every cycle:
- the clocks are gated right after a stop is accepted;
- the block stays stopped without a wake source;
- the counter is at zero outside recovery;
- `wake_done` lasts one cycle and is followed by `stack_ok` with the clocks back on;
- the break flag is set on a break exit and survives a write of 1;
- the clocks stay on in run unless stop is requested.

Only the bench scenarios can show:
- the exact 4096- and 32-cycle recovery lengths;
- that the configuration is captured at stop entry;
- the set-over-clear priority;
- the asynchronous reset during stop and recovery, followed by a fresh count.

// File: rtl/swk_pkg.sv
package swk_pkg;
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_STOP    = 2'd1,
        ST_RECOVER = 2'd2
    } swk_state_e;
endpackage

// File: rtl/swk_rec_counter.sv
// Recovery delay counter. It captures the length selection when stop is
// accepted and counts only while enabled; otherwise it sits at zero.
module swk_rec_counter #(
    parameter int LONG_CYCLES  = 4096,
    parameter int SHORT_CYCLES = 32,
    localparam int CNT_W       = $clog2(LONG_CYCLES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_cfg,
    input  logic             cfg_short,
    input  logic             count_en,
    output logic [CNT_W-1:0] cnt,
    output logic             at_last
);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_CYCLES - 1);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_CYCLES - 1);

    logic             short_sel;
    logic [CNT_W-1:0] last_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            short_sel <= 1'b0;
        end else if (sample_cfg) begin
            short_sel <= cfg_short;
        end
    end

    always_comb begin
        last_val = short_sel ? SHORT_LAST : LONG_LAST;
        at_last  = count_en && (cnt == last_val);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (count_en && !at_last) begin
            cnt <= cnt + 1'b1;
        end else begin
            cnt <= '0;
        end
    end
endmodule

// File: rtl/swk_brk_status.sv
// Sticky break-exit flag: a set wins over a software clear in the same cycle.
module swk_brk_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic wr_en,
    input  logic wr_data,
    output logic flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_ev) begin
            flag <= 1'b1;
        end else if (wr_en && !wr_data) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/swk_fsm.sv
// Run / stop / recover sequencer and its clock-enable outputs.
module swk_fsm
    import swk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_req,
    input  logic       irq_req,
    input  logic       brk_req,
    input  logic       rec_last,
    output swk_state_e state,
    output logic       stop_accept,
    output logic       recovering,
    output logic       brk_exit,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       wake_done,
    output logic       stack_ok
);
    swk_state_e state_nx;
    logic       stack_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:     if (stop_req)            state_nx = ST_STOP;
            ST_STOP:    if (irq_req || brk_req)  state_nx = ST_RECOVER;
            ST_RECOVER: if (rec_last)            state_nx = ST_RUN;
            default:                             state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_RUN;
            stack_q <= 1'b0;
        end else begin
            state   <= state_nx;
            stack_q <= (state == ST_RECOVER) && rec_last;
        end
    end

    always_comb begin
        cpu_clk_en  = 1'b0;
        per_clk_en  = 1'b0;
        stop_accept = 1'b0;
        recovering  = 1'b0;
        brk_exit    = 1'b0;
        wake_done   = 1'b0;
        unique case (state)
            ST_RUN: begin
                cpu_clk_en  = 1'b1;
                per_clk_en  = 1'b1;
                stop_accept = stop_req;
            end
            ST_STOP: begin
                brk_exit = brk_req;
            end
            ST_RECOVER: begin
                recovering = 1'b1;
                wake_done  = rec_last;
            end
            default: begin
                cpu_clk_en = 1'b1;
                per_clk_en = 1'b1;
            end
        endcase
        stack_ok = stack_q;
    end
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl #(
    parameter int LONG_CYCLES  = 4096,
    parameter int SHORT_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    input  logic irq_req,
    input  logic brk_req,
    input  logic cfg_short,
    input  logic reg_wr_en,
    input  logic reg_wr_data,
    output logic brk_flag,
    output logic cpu_clk_en,
    output logic per_clk_en,
    output logic wake_done,
    output logic stack_ok
);
    import swk_pkg::*;

    localparam int CNT_W = $clog2(LONG_CYCLES);

    swk_state_e       state;
    logic [CNT_W-1:0] rec_cnt;
    logic             rec_last;
    logic             stop_accept;
    logic             recovering;
    logic             brk_exit;

    swk_fsm i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .stop_req    (stop_req),
        .irq_req     (irq_req),
        .brk_req     (brk_req),
        .rec_last    (rec_last),
        .state       (state),
        .stop_accept (stop_accept),
        .recovering  (recovering),
        .brk_exit    (brk_exit),
        .cpu_clk_en  (cpu_clk_en),
        .per_clk_en  (per_clk_en),
        .wake_done   (wake_done),
        .stack_ok    (stack_ok)
    );

    swk_rec_counter #(
        .LONG_CYCLES  (LONG_CYCLES),
        .SHORT_CYCLES (SHORT_CYCLES)
    ) i_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_cfg (stop_accept),
        .cfg_short  (cfg_short),
        .count_en   (recovering),
        .cnt        (rec_cnt),
        .at_last    (rec_last)
    );

    swk_brk_status i_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_ev  (brk_exit),
        .wr_en   (reg_wr_en),
        .wr_data (reg_wr_data),
        .flag    (brk_flag)
    );
endmodule

// File: rtl/swk_checker.sv
module swk_checker
    import swk_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stop_req,
    input logic             irq_req,
    input logic             brk_req,
    input logic             reg_wr_en,
    input logic             reg_wr_data,
    input logic             cpu_clk_en,
    input logic             per_clk_en,
    input logic             wake_done,
    input logic             stack_ok,
    input logic             brk_flag,
    input swk_state_e       state,
    input logic [CNT_W-1:0] rec_cnt
);
    a_r2_gate_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && stop_req) |=> (!cpu_clk_en && !per_clk_en));

    a_r3_hold_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && !irq_req && !brk_req) |=> (state == ST_STOP && !cpu_clk_en));

    a_r4_cnt_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RECOVER) |-> (rec_cnt == '0));

    a_r6_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake_done |=> !wake_done);

    a_r7_stack_follows: assert property (@(posedge clk) disable iff (!rst_n)
        wake_done |=> (stack_ok && cpu_clk_en && per_clk_en));

    a_r7_stack_only_after: assert property (@(posedge clk) disable iff (!rst_n)
        stack_ok |-> $past(wake_done));

    a_r8_brk_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && brk_req) |=> brk_flag);

    a_r9_write_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_flag && reg_wr_en && reg_wr_data) |=> brk_flag);

    a_r11_run_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && !stop_req) |=> cpu_clk_en);
endmodule

bind stop_wake_ctrl swk_checker #(.CNT_W(CNT_W)) i_swk_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_req    (stop_req),
    .irq_req     (irq_req),
    .brk_req     (brk_req),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_data (reg_wr_data),
    .cpu_clk_en  (cpu_clk_en),
    .per_clk_en  (per_clk_en),
    .wake_done   (wake_done),
    .stack_ok    (stack_ok),
    .brk_flag    (brk_flag),
    .state       (state),
    .rec_cnt     (rec_cnt)
);

// File: tb/test_stop_wake_ctrl.sv
`timescale 1ns/1ps
module test_stop_wake_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_req = 1'b0, irq_req = 1'b0, brk_req = 1'b0, cfg_short = 1'b0;
    logic reg_wr_en = 1'b0, reg_wr_data = 1'b0;
    logic brk_flag, cpu_clk_en, per_clk_en, wake_done, stack_ok;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    stop_wake_ctrl i_stop_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .irq_req(irq_req),
        .brk_req(brk_req), .cfg_short(cfg_short), .reg_wr_en(reg_wr_en),
        .reg_wr_data(reg_wr_data), .brk_flag(brk_flag), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .wake_done(wake_done), .stack_ok(stack_ok)
    );

    // Vector fields: [17] cfg_short, [16] irq, [15] brk, [14] flip cfg in stop,
    // [13] expected brk_flag, [12:0] expected recovery length.
    localparam logic [17:0] VECS [6] = '{
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 13'd32},
        {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 13'd4096},
        {1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 13'd32},
        {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 13'd32},
        {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 13'd4096},
        {1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 13'd32}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_flag();
        @(negedge clk); reg_wr_en = 1'b1; reg_wr_data = 1'b0;
        @(negedge clk); reg_wr_en = 1'b0;
    endtask

    task automatic enter_stop(input logic cfg);
        @(negedge clk); stop_req = 1'b1; cfg_short = cfg;
        @(negedge clk); stop_req = 1'b0;
        check(!cpu_clk_en && !per_clk_en, "R2 gated after stop", cpu_clk_en, 0);
    endtask

    // Waits in recovery until the clocks return. At entry the bench is in the
    // first recovery cycle.
    task automatic wait_recovery(input int exp_len, input string req);
        int n = 0;
        int wd_cnt = 0;
        int wd_at = -1;
        int stk_bad = 0;
        while (!cpu_clk_en && n < 6000) begin
            if (wake_done) begin wd_cnt++; wd_at = n; end
            if (stack_ok) stk_bad++;
            if (per_clk_en) stk_bad++;
            n++;
            @(negedge clk);
        end
        check(n == exp_len, {req, " recovery length"}, n, exp_len);
        check(wd_cnt == 1 && wd_at == exp_len - 1, "R6 wake_done last cycle", wd_at, exp_len - 1);
        check(stk_bad == 0, "R7 no stack or clocks in recovery", stk_bad, 0);
        check(stack_ok && per_clk_en, "R7 stack_ok first run cycle", stack_ok, 1);
        @(negedge clk);
        check(!stack_ok && cpu_clk_en, "R7 stack_ok single cycle", stack_ok, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(cpu_clk_en && per_clk_en, "R1 clocks on in reset", cpu_clk_en, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(cpu_clk_en && per_clk_en && !brk_flag && !wake_done && !stack_ok,
              "R1 reset state", {brk_flag, wake_done, stack_ok}, 0);

        // Table walk
        for (int v = 0; v < 6; v++) begin
            clear_flag();
            enter_stop(VECS[v][17]);
            repeat (5) @(negedge clk);
            check(!cpu_clk_en, "R3 stays stopped", cpu_clk_en, 0);
            if (VECS[v][14]) cfg_short = ~VECS[v][17];
            irq_req = VECS[v][16]; brk_req = VECS[v][15];
            @(negedge clk);
            irq_req = 1'b0; brk_req = 1'b0;
            wait_recovery(int'(VECS[v][12:0]), VECS[v][14] ? "R5" : "R4");
            check(brk_flag == VECS[v][13], "R8 break flag after wake", brk_flag, VECS[v][13]);
        end

        // R9: write 1 keeps, write 0 clears
        @(negedge clk); reg_wr_en = 1'b1; reg_wr_data = 1'b1;
        @(negedge clk); reg_wr_en = 1'b0;
        check(brk_flag == 1'b1, "R9 write one no effect", brk_flag, 1);
        clear_flag();
        check(brk_flag == 1'b0, "R9 write zero clears", brk_flag, 0);

        // R8 / R11: break and interrupt in run
        @(negedge clk); brk_req = 1'b1; irq_req = 1'b1;
        @(negedge clk); brk_req = 1'b0; irq_req = 1'b0;
        @(negedge clk);
        check(!brk_flag, "R8 break in run ignored", brk_flag, 0);
        check(cpu_clk_en && per_clk_en, "R11 wake sources in run ignored", cpu_clk_en, 1);

        // R9: set and clear in the same cycle, R11: stop_req in recovery
        enter_stop(1'b1);
        brk_req = 1'b1; reg_wr_en = 1'b1; reg_wr_data = 1'b0;
        @(negedge clk);
        brk_req = 1'b0; reg_wr_en = 1'b0;
        check(brk_flag == 1'b1, "R9 set beats clear", brk_flag, 1);
        repeat (3) @(negedge clk);
        stop_req = 1'b1;
        @(negedge clk); stop_req = 1'b0;
        wait_recovery(32 - 4, "R11 stop_req in recovery");
        repeat (3) @(negedge clk);
        check(cpu_clk_en, "R11 still running", cpu_clk_en, 1);

        // R10: reset during stop
        enter_stop(1'b0);
        repeat (4) @(negedge clk);
        rst_n = 1'b0; #1;
        check(cpu_clk_en && per_clk_en && !brk_flag, "R10 reset in stop", cpu_clk_en, 1);
        @(negedge clk); rst_n = 1'b1;

        // R10: reset during long recovery, then a fresh short count
        enter_stop(1'b0);
        irq_req = 1'b1;
        @(negedge clk); irq_req = 1'b0;
        repeat (100) @(negedge clk);
        check(!cpu_clk_en, "R4 still recovering", cpu_clk_en, 0);
        rst_n = 1'b0; #1;
        check(cpu_clk_en && !wake_done && !stack_ok, "R10 reset in recovery", cpu_clk_en, 1);
        @(negedge clk); rst_n = 1'b1;
        enter_stop(1'b1);
        irq_req = 1'b1;
        @(negedge clk); irq_req = 1'b0;
        wait_recovery(32, "R10 fresh count");

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual 0 expected 1");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule